// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the control logic for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It sees only register specifiers, valid bits, instruction-class flags and the branch outcome that the decode stage has already computed. From these it steers the two execute-stage operand multiplexers and drives the pipeline-control signals. Those signals hold the PC and the fetch/decode latch, insert a bubble into execute, squash the fetch/decode latch and redirect fetch to a branch target.

The control covers five situations. A result held in the memory or writeback latch is forwarded to a dependent instruction in execute. A load followed at once by a consumer costs one interlock cycle. Fetch and data access share a single memory port, so fetch waits while a load or store is in the memory stage. Branches are predicted not taken and resolved in decode, and a taken branch squashes the fetched instruction behind it. Floating-point results come with a fixed consumer gap, enforced by a per-register countdown scoreboard. The decision logic is combinational because it must act within the same cycle. The only state is the scoreboard, which uses a synchronous active-high reset.

Top module: `hz_ctl_top`

## Requirements
- R1: Each operand select `fwd_a`/`fwd_b` is 0 (register file), 1 (take the memory-stage latch) or 2 (take the writeback-stage latch). When both stages write the execute source register, the memory stage wins. The value 3 never appears.
- R2: A memory-stage or writeback-stage entry is a forwarding source only when it is valid, writes a register and its destination is not register 0. A load in the memory stage is never a memory-stage forwarding source, so it can only be taken from writeback.
- R3: When execute holds a valid register-writing load whose nonzero destination equals either decode source, and decode is valid, `pc_hold`, `ifid_hold` and `ex_bubble` are 1 in that cycle.
- R4: When execute holds a valid register-writing floating-point operation with nonzero destination d, a valid decode instruction that reads d is held in three places: in that cycle, in the following FP_GAP-1 cycles, and wherever `pc_hold`, `ifid_hold` and `ex_bubble` are 1.
- R5: With no data interlock and no taken branch, a valid load or store in the memory stage gives `pc_hold`=1 and `ifid_flush`=1, with `ifid_hold`=0 and `ex_bubble`=0.
- R6: A valid decode branch with `id_taken`=1 and no data interlock gives `redirect`=1, `ifid_flush`=1 and `pc_hold`=0, whether or not the memory stage is busy. A branch with `id_taken`=0 adds nothing.
- R7: When a data interlock (R3 or R4) and a taken branch meet, `redirect` and `ifid_flush` are 0 and the interlock outputs are 1.
- R8: With no hazard, all of `pc_hold`, `ifid_hold`, `ex_bubble`, `ifid_flush` and `redirect` are 0.
- R9: Reset clears every scoreboard countdown. After reset, an earlier floating-point producer causes no interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_W | Decode source register 1 |
| id_rs2 | input | REG_W | Decode source register 2 |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_taken | input | 1 | Branch outcome computed in decode |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_rs1 | input | REG_W | Execute source register 1 |
| ex_rs2 | input | REG_W | Execute source register 2 |
| ex_rd | input | REG_W | Execute destination register |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_fp | input | 1 | Execute instruction is floating-point arithmetic |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_rd | input | REG_W | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_rd | input | REG_W | Writeback destination register |
| wb_wr | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Operand 1 select (R1 encoding) |
| fwd_b | output | 2 | Operand 2 select (R1 encoding) |
| pc_hold | output | 1 | PC keeps its value |
| ifid_hold | output | 1 | Fetch/decode latch keeps its value |
| ex_bubble | output | 1 | Decode/execute latch loads a bubble |
| ifid_flush | output | 1 | Fetch/decode latch loads a bubble |
| redirect | output | 1 | PC loads the branch target |

## Verification
The bench builds the block with REG_W=5 and FP_GAP=3 instead of the default gap of 2. This makes the scoreboard hold a countdown longer than one cycle, so a consumer stalls for three consecutive cycles and the countdown reloads while still running. Random register specifiers are drawn from registers 0 to 3. This makes source/destination matches, register-0 producers and overlaps of forwarding with load, floating-point, structural and branch hazards frequent, on top of the directed cases.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NOPS  = 2
) (
  input  logic [NOPS-1:0][REG_W-1:0] ex_src,
  input  logic                       mem_ok,
  input  logic [REG_W-1:0]           mem_rd,
  input  logic                       wb_ok,
  input  logic [REG_W-1:0]           wb_rd,
  output fwd_sel_e [NOPS-1:0]        sel
);

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    always_comb begin
      if (mem_ok && (mem_rd == ex_src[i]))
        sel[i] = FWD_MEM;
      else if (wb_ok && (wb_rd == ex_src[i]))
        sel[i] = FWD_WB;
      else
        sel[i] = FWD_RF;
    end
  end

endmodule

// File: rtl/hz_fp_board.sv
module hz_fp_board #(
  parameter int REG_W  = 5,
  parameter int FP_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_ok,
  input  logic [REG_W-1:0] issue_rd,
  input  logic [REG_W-1:0] rd_a,
  input  logic [REG_W-1:0] rd_b,
  output logic             busy_a,
  output logic             busy_b
);

  localparam int NREG  = 1 << REG_W;
  localparam int CNT_W = (FP_GAP > 1) ? $clog2(FP_GAP) : 1;
  localparam logic [CNT_W-1:0] LOADV = CNT_W'(FP_GAP - 1);

  logic [NREG-1:0] pend;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)
        cnt <= '0;
      else if (issue_ok && (issue_rd == REG_W'(r)))
        cnt <= LOADV;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
    assign pend[r] = (cnt != '0);
  end

  assign busy_a = pend[rd_a];
  assign busy_b = pend[rd_b];

endmodule

// File: rtl/hz_pipe_ctl.sv
module hz_pipe_ctl (
  input  logic data_stall,
  input  logic br_taken,
  input  logic mem_busy,
  output logic pc_hold,
  output logic ifid_hold,
  output logic ex_bubble,
  output logic ifid_flush,
  output logic redirect
);

  always_comb begin
    pc_hold    = 1'b0;
    ifid_hold  = 1'b0;
    ex_bubble  = 1'b0;
    ifid_flush = 1'b0;
    redirect   = 1'b0;
    if (data_stall) begin
      pc_hold   = 1'b1;
      ifid_hold = 1'b1;
      ex_bubble = 1'b1;
    end else if (br_taken) begin
      redirect   = 1'b1;
      ifid_flush = 1'b1;
    end else if (mem_busy) begin
      pc_hold    = 1'b1;
      ifid_flush = 1'b1;
    end
  end

endmodule

// File: rtl/hz_ctl_top.sv
module hz_ctl_top
  import hz_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int FP_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_branch,
  input  logic             id_taken,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic             ex_fp,
  input  logic             mem_valid,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wr,
  input  logic             mem_load,
  input  logic             mem_store,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_wr,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_hold,
  output logic             ifid_hold,
  output logic             ex_bubble,
  output logic             ifid_flush,
  output logic             redirect
);

  logic ex_prod, mem_ok, wb_ok;
  logic ex_reads_hit, ld_stall, fp_now, fp_pend_a, fp_pend_b, fp_stall;
  logic [1:0][REG_W-1:0] ex_src;
  fwd_sel_e [1:0] sel;

  assign ex_prod = ex_valid && ex_wr && (ex_rd != '0);
  assign mem_ok  = mem_valid && mem_wr && !mem_load && (mem_rd != '0);
  assign wb_ok   = wb_valid && wb_wr && (wb_rd != '0);
  assign ex_src  = {ex_rs2, ex_rs1};

  hz_fwd_unit #(.REG_W(REG_W), .NOPS(2)) fwd_i (
    .ex_src (ex_src),
    .mem_ok (mem_ok),
    .mem_rd (mem_rd),
    .wb_ok  (wb_ok),
    .wb_rd  (wb_rd),
    .sel    (sel)
  );

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  assign ex_reads_hit = ex_prod && id_valid && ((ex_rd == id_rs1) || (ex_rd == id_rs2));
  assign ld_stall     = ex_reads_hit && ex_load;
  assign fp_now       = ex_reads_hit && ex_fp;

  hz_fp_board #(.REG_W(REG_W), .FP_GAP(FP_GAP)) board_i (
    .clk      (clk),
    .rst      (rst),
    .issue_ok (ex_prod && ex_fp),
    .issue_rd (ex_rd),
    .rd_a     (id_rs1),
    .rd_b     (id_rs2),
    .busy_a   (fp_pend_a),
    .busy_b   (fp_pend_b)
  );

  assign fp_stall = fp_now || (id_valid && (fp_pend_a || fp_pend_b));

  hz_pipe_ctl ctl_i (
    .data_stall (ld_stall || fp_stall),
    .br_taken   (id_valid && id_branch && id_taken),
    .mem_busy   (mem_valid && (mem_load || mem_store)),
    .pc_hold    (pc_hold),
    .ifid_hold  (ifid_hold),
    .ex_bubble  (ex_bubble),
    .ifid_flush (ifid_flush),
    .redirect   (redirect)
  );

endmodule

// File: rtl/hz_ctl_chk.sv
module hz_ctl_chk #(
  parameter int REG_W  = 5,
  parameter int FP_GAP = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             id_valid,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic             id_branch,
  input logic             id_taken,
  input logic             ex_valid,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_wr,
  input logic             ex_load,
  input logic             ex_fp,
  input logic             mem_valid,
  input logic             mem_load,
  input logic             mem_store,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             pc_hold,
  input logic             ifid_hold,
  input logic             ex_bubble,
  input logic             ifid_flush,
  input logic             redirect
);

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (fwd_a != 2'd3) && (fwd_b != 2'd3)); // R1

  AST_LOAD_USE: assert property (@(posedge clk) disable iff (rst)
    (id_valid && ex_valid && ex_wr && ex_load && (ex_rd != '0) &&
     ((ex_rd == id_rs1) || (ex_rd == id_rs2))) |-> (ifid_hold && ex_bubble && pc_hold)); // R3

  AST_FP_NEXT: assert property (@(posedge clk) disable iff (rst)
    ((FP_GAP >= 2) && !$past(rst) && $past(ex_valid && ex_wr && ex_fp && (ex_rd != '0)) &&
     id_valid && (id_rs1 == $past(ex_rd))) |-> ifid_hold); // R4

  AST_STRUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && (mem_load || mem_store) && !ifid_hold && !redirect) |-> (pc_hold && ifid_flush && !ex_bubble)); // R5

  AST_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (ifid_flush && !pc_hold && id_valid && id_branch && id_taken)); // R6

  AST_STALL_WINS: assert property (@(posedge clk) disable iff (rst)
    ifid_hold |-> (!redirect && !ifid_flush && ex_bubble && pc_hold)); // R7

  AST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!id_valid && !mem_valid) |-> !(pc_hold || ifid_hold || ex_bubble || ifid_flush || redirect)); // R8

endmodule

bind hz_ctl_top hz_ctl_chk #(.REG_W(REG_W), .FP_GAP(FP_GAP)) chk_i (.*);

// File: tb/hz_ctl_top_tb_top.sv
module hz_ctl_top_tb_top;

  localparam int REG_W  = 5;
  localparam int FP_GAP = 3;
  localparam int NREG   = 1 << REG_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_valid, id_branch, id_taken;
  logic [REG_W-1:0] id_rs1, id_rs2;
  logic ex_valid, ex_wr, ex_load, ex_fp;
  logic [REG_W-1:0] ex_rs1, ex_rs2, ex_rd;
  logic mem_valid, mem_wr, mem_load, mem_store;
  logic [REG_W-1:0] mem_rd;
  logic wb_valid, wb_wr;
  logic [REG_W-1:0] wb_rd;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, ex_bubble, ifid_flush, redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cnt_q[NREG];

  always #2.5 clk = ~clk;

  hz_ctl_top #(.REG_W(REG_W), .FP_GAP(FP_GAP)) dut_i (.*);

  task automatic idle();
    id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_branch = 0; id_taken = 0;
    ex_valid = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; ex_wr = 0; ex_load = 0; ex_fp = 0;
    mem_valid = 0; mem_rd = 0; mem_wr = 0; mem_load = 0; mem_store = 0;
    wb_valid = 0; wb_rd = 0; wb_wr = 0;
  endtask

  function automatic int exp_sel(logic [REG_W-1:0] src);
    bit m = mem_valid && mem_wr && !mem_load && mem_rd != 0;
    bit w = wb_valid && wb_wr && wb_rd != 0;
    if (m && mem_rd == src) return 1;
    if (w && wb_rd == src) return 2;
    return 0;
  endfunction

  // compare all outputs against the model, then advance the model at the edge
  task automatic step(string force_tag);
    int ea, eb;
    bit hit, ld, fp, ds, br, busy;
    bit e_pc, e_hold, e_bub, e_fl, e_rd;
    string tf, tc;
    #1;
    ea = exp_sel(ex_rs1);
    eb = exp_sel(ex_rs2);
    hit = id_valid && ex_valid && ex_wr && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    ld = hit && ex_load;
    fp = (hit && ex_fp) || (id_valid && (cnt_q[id_rs1] > 0 || cnt_q[id_rs2] > 0));
    ds = ld || fp;
    br = id_valid && id_branch && id_taken;
    busy = mem_valid && (mem_load || mem_store);
    e_hold = ds; e_bub = ds;
    e_pc = ds || (!br && busy);
    e_fl = !ds && (br || busy);
    e_rd = !ds && br;
    tf = (mem_valid && mem_wr && mem_load) || mem_rd == 0 || wb_rd == 0 ? "R2" : "R1";
    if (ds && br) tc = "R7";
    else if (fp) tc = "R4";
    else if (ld) tc = "R3";
    else if (br) tc = "R6";
    else if (busy) tc = "R5";
    else tc = "R8";
    if (force_tag != "") begin tf = force_tag; tc = force_tag; end
    checks++;
    if (fwd_a != ea[1:0] || fwd_b != eb[1:0]) begin
      errors++;
      $display("FAIL %s fwd a/b got %0d/%0d exp %0d/%0d", tf, fwd_a, fwd_b, ea, eb);
    end
    checks++;
    if ({pc_hold, ifid_hold, ex_bubble, ifid_flush, redirect} != {e_pc, e_hold, e_bub, e_fl, e_rd}) begin
      errors++;
      $display("FAIL %s ctl pc/hold/bub/flush/redir got %b exp %b", tc,
               {pc_hold, ifid_hold, ex_bubble, ifid_flush, redirect},
               {e_pc, e_hold, e_bub, e_fl, e_rd});
    end
    @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      if (rst) cnt_q[r] = 0;
      else if (ex_valid && ex_wr && ex_fp && ex_rd != 0 && ex_rd == r) cnt_q[r] = FP_GAP - 1;
      else if (cnt_q[r] > 0) cnt_q[r]--;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) cnt_q[r] = 0;
    idle();
    @(negedge clk);
    step("R8"); step("R8");              // reset state: quiet outputs
    rst = 0;
    // R1 back-to-back ALU forwarding from memory stage, then writeback
    ex_valid = 1; ex_rs1 = 3; ex_rs2 = 4; mem_valid = 1; mem_wr = 1; mem_rd = 3;
    step("R1");
    idle(); ex_valid = 1; ex_rs1 = 3; ex_rs2 = 3; wb_valid = 1; wb_wr = 1; wb_rd = 3;
    step("R1");
    // R1 priority: both stages write r5, memory stage must win
    idle(); ex_valid = 1; ex_rs1 = 5; ex_rs2 = 5;
    mem_valid = 1; mem_wr = 1; mem_rd = 5; wb_valid = 1; wb_wr = 1; wb_rd = 5;
    step("R1");
    // R2 register 0 and load in memory stage are not memory-stage sources
    idle(); ex_valid = 1; ex_rs1 = 0; mem_valid = 1; mem_wr = 1; mem_rd = 0;
    step("R2");
    idle(); ex_valid = 1; ex_rs1 = 6; mem_valid = 1; mem_wr = 1; mem_load = 1; mem_rd = 6;
    wb_valid = 1; wb_wr = 1; wb_rd = 6;
    step("R2");
    // R3 load-use
    idle(); id_valid = 1; id_rs2 = 7; ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 7;
    step("R3");
    // R4 FP window of FP_GAP cycles, consumer held each cycle
    idle(); id_valid = 1; id_rs1 = 9; ex_valid = 1; ex_wr = 1; ex_fp = 1; ex_rd = 9;
    step("R4");
    idle(); id_valid = 1; id_rs1 = 9; step("R4"); step("R4");
    step("R4");                           // window over: consumer free
    // R5 structural conflict on the shared memory port
    idle(); mem_valid = 1; mem_store = 1; step("R5");
    // R6 taken branch, also while memory busy; not-taken costs nothing
    idle(); id_valid = 1; id_branch = 1; id_taken = 1; step("R6");
    mem_valid = 1; mem_load = 1; step("R6");
    idle(); id_valid = 1; id_branch = 1; id_taken = 0; step("R8");
    // R7 load-use together with a taken branch
    idle(); id_valid = 1; id_branch = 1; id_taken = 1; id_rs1 = 2;
    ex_valid = 1; ex_wr = 1; ex_load = 1; ex_rd = 2;
    step("R7");
    // R9 reset clears a pending FP countdown
    idle(); ex_valid = 1; ex_wr = 1; ex_fp = 1; ex_rd = 10; rst = 1;
    step("R9");
    idle(); rst = 0; id_valid = 1; id_rs1 = 10;
    step("R9");
    // random mixes over a narrow register range
    for (int n = 0; n < 3000; n++) begin
      id_valid = 1'($urandom_range(0, 1)); id_rs1 = REG_W'($urandom_range(0, 3));
      id_rs2 = REG_W'($urandom_range(0, 3)); id_branch = 1'($urandom_range(0, 1));
      id_taken = 1'($urandom_range(0, 1));
      ex_valid = 1'($urandom_range(0, 1)); ex_rs1 = REG_W'($urandom_range(0, 3));
      ex_rs2 = REG_W'($urandom_range(0, 3)); ex_rd = REG_W'($urandom_range(0, 3));
      ex_wr = 1'($urandom_range(0, 1)); ex_load = ($urandom_range(0, 3) == 0);
      ex_fp = !ex_load && ($urandom_range(0, 3) == 0);
      mem_valid = 1'($urandom_range(0, 1)); mem_rd = REG_W'($urandom_range(0, 3));
      mem_wr = 1'($urandom_range(0, 1)); mem_load = ($urandom_range(0, 3) == 0);
      mem_store = !mem_load && ($urandom_range(0, 4) == 0);
      wb_valid = 1'($urandom_range(0, 1)); wb_rd = REG_W'($urandom_range(0, 3));
      wb_wr = 1'($urandom_range(0, 1));
      step("");
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule